// File: doc/BRIEF.md
# Fractional Sigma-Delta Tick Divider

This block produces the count-enable strobe that advances one PWM channel's counter. In its free-running mode it slows the system clock by a ratio made of an 8-bit whole part and a 4-bit fraction in sixteenths. The fraction is realised by first-order sigma-delta dithering. Some periods last one clock longer than the whole part, so that the average spacing of the strobes equals the programmed ratio.

Three further modes take their timing from an external input pin. One lets the divider run only while the pin is high. The other two issue one strobe for each rising or each falling transition of the pin. The pin passes through a two-flop synchroniser first, so it may be fully asynchronous to the clock. When the channel enable is low, the block issues no strobes, and its period counter and fraction accumulator return to zero.

Top module: `frac_tick_div`

## Requirements
- R1: While `rst` is high, and on the first sampled cycle after it falls, `tick` is 0 whatever the other inputs are.
- R2: With `mode` = 0 (free running) and `enable` = 1, the distance from any tick to the sixteenth tick after it is exactly 16*I + F clocks. Here I is `div_int` and F is `div_frac`.
- R3: In mode 0, every tick-to-tick interval is either I or I+1 clocks. The shortest interval seen is I.
- R4: A `div_int` of 0 counts as I = 256.
- R5: With `mode` = 1 (pin-gated), ticks are spaced as in mode 0 while the synchronised pin is high. No tick appears while it is low, the period counter holds its count, and ticks resume when the pin returns high.
- R6: With `mode` = 2, each rising transition of `ext_pin` gives exactly one tick, falling transitions give none, and the divider settings have no effect.
- R7: With `mode` = 3, each falling transition of `ext_pin` gives exactly one tick, and rising transitions give none.
- R8: While `enable` is 0, no tick is issued in any mode, and the period counter and fraction accumulator clear. After re-enabling with I = 2 and F = 8, the first two intervals are 2 then 3 clocks.
- R9: In modes 2 and 3, a pin transition set up before clock edge n produces `tick` high only after edge n+2, for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel enable; low stops ticks and clears divider state |
| mode | input | 2 | 0 free-running, 1 pin-gated, 2 rising edges, 3 falling edges |
| div_int | input | INT_W (8) | Whole part of the ratio; 0 means 256 |
| div_frac | input | FRAC_W (4) | Fractional part of the ratio in sixteenths |
| ext_pin | input | 1 | External input pin, asynchronous |
| tick | output | 1 | Registered count-enable strobe |

## Verification
The bench measures spans of sixteen intervals for several ratios. These include a fraction of 15, a whole part of 1, and the 0-means-256 case. A divider that places the dither carry wrongly or loses it would show spans off by the fraction, and one that reads a zero whole part as zero would tick continuously. Re-enabling right after a tick that left the accumulator at 8 exposes a design that keeps the accumulator across a disable, because the intervals would then arrive as 3, 2 instead of 2, 3. Pulse trains in the edge modes, and the exact three-edge latency, catch a design that ticks on both edges, skips a synchroniser stage, or lets the divider leak through.

// File: rtl/tickdiv_pkg.sv
package tickdiv_pkg;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_GATED = 2'd1,
    MODE_RISE  = 2'd2,
    MODE_FALL  = 2'd3
  } tick_mode_e;

  localparam int DEF_INT_W  = 8;
  localparam int DEF_FRAC_W = 4;
  localparam int DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/tickdiv_pin_sync.sv
module tickdiv_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

  // R6: a detected rising edge can never repeat on the next cycle
  a_r6_rise_spaced: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

  // R7: same spacing for falling edges
  a_r7_fall_spaced: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);

endmodule

// File: rtl/tickdiv_sd_period.sv
module tickdiv_sd_period #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              run,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              fire
);

  localparam int CNT_W = INT_W + 1;
  localparam logic [CNT_W-1:0] FULL_PERIOD = CNT_W'(1) << INT_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              stretch_q;

  logic [CNT_W-1:0]  whole_len;
  logic [CNT_W-1:0]  last_idx;
  logic [FRAC_W:0]   acc_sum;

  always_comb begin
    whole_len = (div_int == '0) ? FULL_PERIOD : {1'b0, div_int};
    last_idx  = whole_len + {{INT_W{1'b0}}, stretch_q} - CNT_W'(1);
    acc_sum   = {1'b0, acc_q} + {1'b0, div_frac};
    fire      = run && (cnt_q >= last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      stretch_q <= 1'b0;
    end else if (run) begin
      if (fire) begin
        cnt_q     <= '0;
        acc_q     <= acc_sum[FRAC_W-1:0];
        stretch_q <= acc_sum[FRAC_W];
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R4: the count never passes the longest period
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_PERIOD);

  // R5: a paused divider keeps its count and accumulator
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!clear && !run) |=> ($stable(cnt_q) && $stable(acc_q)));

  // R8: disabling empties all divider state
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt_q == '0 && acc_q == '0 && !stretch_q));

endmodule

// File: rtl/tickdiv_tick_gen.sv
module tickdiv_tick_gen
  import tickdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  tick_mode_e mode,
  input  logic       pin_level,
  input  logic       pin_rise,
  input  logic       pin_fall,
  input  logic       div_fire,
  output logic       run,
  output logic       tick
);

  logic event_now;

  always_comb begin
    run       = 1'b0;
    event_now = 1'b0;
    case (mode)
      MODE_FREE:  begin run = enable;             event_now = div_fire; end
      MODE_GATED: begin run = enable & pin_level; event_now = div_fire; end
      MODE_RISE:  event_now = pin_rise;
      MODE_FALL:  event_now = pin_fall;
      default:    event_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= enable & event_now;
  end

  // R8: a disabled cycle is followed by a quiet output
  a_r8_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !tick);

  // R5: in gated mode the divider only runs while the pin is high
  a_r5_gate_low: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_GATED && !pin_level) |-> !run);

endmodule

// File: rtl/frac_tick_div.sv
module frac_tick_div
  import tickdiv_pkg::*;
#(
  parameter int INT_W       = DEF_INT_W,
  parameter int FRAC_W      = DEF_FRAC_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              ext_pin,
  output logic              tick
);

  logic pin_level, pin_rise, pin_fall;
  logic div_fire, run;

  tickdiv_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pin_async (ext_pin),
    .level     (pin_level),
    .rise      (pin_rise),
    .fall      (pin_fall)
  );

  tickdiv_sd_period #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_period (
    .clk      (clk),
    .rst      (rst),
    .clear    (!enable),
    .run      (run),
    .div_int  (div_int),
    .div_frac (div_frac),
    .fire     (div_fire)
  );

  tickdiv_tick_gen u_gen (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .mode      (tick_mode_e'(mode)),
    .pin_level (pin_level),
    .pin_rise  (pin_rise),
    .pin_fall  (pin_fall),
    .div_fire  (div_fire),
    .run       (run),
    .tick      (tick)
  );

endmodule

// File: tb/test_frac_tick_div.sv
`timescale 1ns/1ps
module test_frac_tick_div;

  logic       clk = 1'b0;
  logic       rst;
  logic       enable;
  logic [1:0] mode;
  logic [7:0] div_int;
  logic [3:0] div_frac;
  logic       ext_pin;
  logic       tick;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int ivs [0:31];

  // whole part, fraction, expected span of 16 intervals
  localparam int VEC [7][3] = '{
    '{4, 0, 64}, '{2, 8, 40}, '{1, 8, 24}, '{3, 15, 63},
    '{0, 5, 4101}, '{7, 1, 113}, '{1, 0, 16}
  };

  always #2.5 clk = ~clk;

  frac_tick_div i_frac_tick_div (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode),
    .div_int(div_int), .div_frac(div_frac), .ext_pin(ext_pin), .tick(tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic collect(input int n, output bit ok);
    int c = 0;
    int last = -1;
    int got = 0;
    ok = 1'b1;
    while (got < n) begin
      @(negedge clk);
      c++;
      if (c > 20000) begin ok = 1'b0; break; end
      if (tick) begin
        if (last >= 0) begin ivs[got] = c - last; got++; end
        last = c;
      end
    end
  endtask

  task automatic count_ticks(input int cycles, output int cnt);
    cnt = 0;
    repeat (cycles) begin @(negedge clk); cnt += int'(tick); end
  endtask

  task automatic pulse_train(input int pulses, output int cnt);
    cnt = 0;
    for (int p = 0; p < pulses; p++) begin
      ext_pin = 1'b1;
      repeat (3) begin @(negedge clk); cnt += int'(tick); end
      ext_pin = 1'b0;
      repeat (3) begin @(negedge clk); cnt += int'(tick); end
    end
    repeat (6) begin @(negedge clk); cnt += int'(tick); end
  endtask

  initial begin
    bit ok;
    int cnt, span, mn, mx, ival;
    rst = 1'b1; enable = 1'b0; mode = 2'd0; div_int = 8'd1; div_frac = 4'd0; ext_pin = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1 tick during reset", int'(tick), 0);
    enable = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tick == 1'b0, "R1 tick after reset", int'(tick), 0);

    // table of free-running ratios (R2, R3, R4)
    for (int v = 0; v < 7; v++) begin
      enable = 1'b0; mode = 2'd0;
      div_int = 8'(VEC[v][0]); div_frac = 4'(VEC[v][1]);
      @(negedge clk);
      enable = 1'b1;
      collect(16, ok);
      check(ok, "R2 ticks present", int'(ok), 1);
      span = 0; mn = 1 << 20; mx = 0;
      for (int k = 0; k < 16; k++) begin
        span += ivs[k];
        if (ivs[k] < mn) mn = ivs[k];
        if (ivs[k] > mx) mx = ivs[k];
      end
      ival = (VEC[v][0] == 0) ? 256 : VEC[v][0];
      if (VEC[v][0] == 0) check(span == VEC[v][2], "R4 span with zero whole part", span, VEC[v][2]);
      else                check(span == VEC[v][2], "R2 span of 16 intervals", span, VEC[v][2]);
      check(mn == ival && mx <= ival + 1, "R3 shortest interval", mn, ival);
      check(mx <= ival + 1, "R3 longest interval", mx, ival + 1);
    end

    // R8: quiet while disabled, in divider and edge modes
    enable = 1'b0; div_int = 8'd1; div_frac = 4'd0; mode = 2'd0;
    @(negedge clk);
    count_ticks(20, cnt);
    check(cnt == 0, "R8 disabled free mode", cnt, 0);
    mode = 2'd2;
    pulse_train(5, cnt);
    check(cnt == 0, "R8 disabled edge mode", cnt, 0);

    // R8: accumulator cleared by disable
    mode = 2'd0; div_int = 8'd2; div_frac = 4'd8;
    @(negedge clk);
    enable = 1'b1;
    cnt = 0;
    while (!tick && cnt < 50) begin @(negedge clk); cnt++; end
    enable = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    collect(2, ok);
    check(ok && ivs[0] == 2, "R8 first interval after re-enable", ivs[0], 2);
    check(ok && ivs[1] == 3, "R8 second interval after re-enable", ivs[1], 3);

    // R5: pin-gated mode
    enable = 1'b0; mode = 2'd1; div_int = 8'd3; div_frac = 4'd0; ext_pin = 1'b1;
    repeat (4) @(negedge clk);
    enable = 1'b1;
    collect(4, ok);
    span = ivs[0] + ivs[1] + ivs[2] + ivs[3];
    check(ok && span == 12, "R5 gated span with pin high", span, 12);
    ext_pin = 1'b0;
    repeat (4) @(negedge clk);
    count_ticks(40, cnt);
    check(cnt == 0, "R5 no ticks with pin low", cnt, 0);
    ext_pin = 1'b1;
    collect(2, ok);
    check(ok && ivs[0] + ivs[1] == 6, "R5 resumes with pin high", ivs[0] + ivs[1], 6);

    // R6: rising edges
    enable = 1'b0; ext_pin = 1'b0; mode = 2'd2; div_int = 8'd1;
    repeat (4) @(negedge clk);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    pulse_train(10, cnt);
    check(cnt == 10, "R6 one tick per rising edge", cnt, 10);

    // R7: falling edges
    mode = 2'd3;
    repeat (4) @(negedge clk);
    pulse_train(10, cnt);
    check(cnt == 10, "R7 one tick per falling edge", cnt, 10);

    // R9: latency through the synchroniser
    mode = 2'd2;
    repeat (4) @(negedge clk);
    ext_pin = 1'b1;
    @(negedge clk);
    check(tick == 1'b0, "R9 no tick after first edge", int'(tick), 0);
    @(negedge clk);
    check(tick == 1'b0, "R9 no tick after second edge", int'(tick), 0);
    @(negedge clk);
    check(tick == 1'b1, "R9 tick after third edge", int'(tick), 1);
    @(negedge clk);
    check(tick == 1'b0, "R9 tick lasts one cycle", int'(tick), 0);
    ext_pin = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule